// File: doc/BRIEF.md
# Z-Stack Acquisition Trigger Sequencer

This block times every trigger of one finite volumetric acquisition without help from the host. A single accepted start pulse launches a run. A scanner pair is emitted: trigger A at once, and trigger B after a programmable phase offset. In parallel, a startup delay runs. Then, for each of the programmed number of axial positions, the block waits for the stage to report ready. Ready means the stage-sync input is low. It then fires a frame event made of two triggers, camera/laser and remote-focus, separated by a programmable offset. A programmable sweep time after the frame event, it issues a stage-advance trigger.

A mode input selects the order of the frame triggers. Low puts the camera/laser trigger first and the remote-focus trigger second; high reverses them. All delays are clock-cycle counts, and a count of zero means the dependent trigger comes one cycle after its cause. A done pulse marks a completed run. A stop input aborts the run at any time and gives no done pulse.

Top module: `zs_trig_seq`

## Requirements
- R1: After reset, every trigger output, `busy_o` and `done_o` are low.
- R2: An accepted start (start high, stop low, `busy_o` low, step count nonzero) makes `scan_a_o` pulse in cycle k=0 (the cycle after the start edge) and `scan_b_o` pulse in cycle k=phase+1, each once per run.
- R3: With the stage ready throughout, the first frame event fires in cycle k=start_dly+2.
- R4: A frame event fires only in the cycle after a clock edge at which `stage_sync_i` was sampled low with the block waiting for ready; while the input stays high, no frame event fires and `busy_o` stays high.
- R5: With `mode_swap_i` latched low, `cam_trig_o` pulses at frame cycle f and `focus_trig_o` pulses at f+focus_dly+1.
- R6: With `mode_swap_i` latched high, `focus_trig_o` pulses at f and `cam_trig_o` pulses at f+focus_dly+1.
- R7: `stage_trig_o` pulses at f+sweep_dly+1 for every frame event.
- R8: Exactly num_steps frame events occur. The next frame event with the stage ready comes at f+max(focus_dly,sweep_dly)+2. `done_o` pulses once at f+max(focus_dly,sweep_dly)+1 of the last step, after which `busy_o` is low.
- R9: When `stop_i` is high at a clock edge, all outputs are low and `busy_o` is low from the next cycle on, and no further trigger or done pulse follows.
- R10: A start pulse while `busy_o` is high is ignored and leaves the running schedule unchanged.
- R11: An accepted start with a step count of zero pulses `done_o` in cycle k=0, emits no trigger and leaves `busy_o` low.
- R12: Mode, start delay, phase, focus offset, sweep time and step count are sampled at the start edge. Changing them during a run has no effect on that run.
- R13: With the default pulse width parameter of 1, every trigger output and `done_o` pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Run launch pulse |
| stop_i | input | 1 | Abort request |
| mode_swap_i | input | 1 | 0: camera first, 1: remote focus first |
| phase_dly_i | input | CNT_W | Cycles between scanner triggers A and B |
| start_dly_i | input | CNT_W | Startup delay before the first frame |
| focus_dly_i | input | CNT_W | Offset between first and second frame trigger |
| sweep_dly_i | input | CNT_W | Cycles from frame event to stage advance |
| num_steps_i | input | STEP_W | Number of axial positions |
| stage_sync_i | input | 1 | Stage busy; low means ready for exposure |
| scan_a_o | output | 1 | Scanner trigger A |
| scan_b_o | output | 1 | Scanner trigger B |
| cam_trig_o | output | 1 | Camera/laser trigger |
| focus_trig_o | output | 1 | Remote-focus trigger |
| stage_trig_o | output | 1 | Stage-advance trigger |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run completed |

## Verification
Each result is due a fixed number of cycles after its cause, counted from the start edge (k=0). Scanner B is due at phase+1. The first frame is due at start_dly+2, or one cycle after the edge that sampled stage-sync low. The second frame trigger is due at f+focus+1 and the stage advance at f+sweep+1. Done and the next frame are due at f+max+1 and f+max+2. The driver converts these into absolute cycle numbers before the start pulse is driven. The monitor compares all six outputs in every cycle against the expected set for that cycle number, so an early, late, missing or spurious pulse is reported.

// File: rtl/zs_pkg.sv
package zs_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_STARTUP,
      ST_WAIT_RDY,
      ST_FRAME
   } seq_state_e;

   localparam int N_CH      = 5;
   localparam int CH_SCAN_A = 0;
   localparam int CH_SCAN_B = 1;
   localparam int CH_CAM    = 2;
   localparam int CH_FOCUS  = 3;
   localparam int CH_STAGE  = 4;
endpackage

// File: rtl/zs_delay_cnt.sv
// Loadable down counter: fire_o rises val_i cycles after the load cycle's edge.
module zs_delay_cnt #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] val_i,
   output logic             run_o,
   output logic             fire_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (clr_i) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (load_i) begin
         run_q <= 1'b1;
         cnt_q <= val_i;
      end else if (run_q) begin
         if (cnt_q == '0) run_q <= 1'b0;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

   assign run_o  = run_q;
   assign fire_o = run_q && (cnt_q == '0);
endmodule

// File: rtl/zs_scan_pair.sv
// Scanner pair: request A at launch, request B after the phase offset.
module zs_scan_pair #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch_i,
   input  logic             abort_i,
   input  logic [CNT_W-1:0] phase_i,
   output logic             a_set_o,
   output logic             b_set_o,
   output logic             busy_o
);
   logic ph_fire;

   zs_delay_cnt #(.CNT_W(CNT_W)) u_phase (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (abort_i),
      .load_i (launch_i),
      .val_i  (phase_i),
      .run_o  (busy_o),
      .fire_o (ph_fire)
   );

   assign a_set_o = launch_i && !abort_i;
   assign b_set_o = ph_fire && !abort_i;
endmodule

// File: rtl/zs_trig_route.sv
// Routes frame requests to camera/focus by mode and registers every channel.
module zs_trig_route import zs_pkg::*; #(
   parameter int PULSE_CYC = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic abort_i,
   input  logic swap_i,
   input  logic scan_a_i,
   input  logic scan_b_i,
   input  logic first_i,
   input  logic second_i,
   input  logic stage_i,
   output logic scan_a_o,
   output logic scan_b_o,
   output logic cam_o,
   output logic focus_o,
   output logic stage_o
);
   localparam int PW_W = $clog2(PULSE_CYC + 1);

   logic [N_CH-1:0] set_v;
   logic [N_CH-1:0] out_v;

   always_comb begin
      set_v            = '0;
      set_v[CH_SCAN_A] = scan_a_i;
      set_v[CH_SCAN_B] = scan_b_i;
      set_v[CH_CAM]    = swap_i ? second_i : first_i;
      set_v[CH_FOCUS]  = swap_i ? first_i  : second_i;
      set_v[CH_STAGE]  = stage_i;
   end

   for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
      if (PULSE_CYC == 1) begin : g_single
         logic q;
         always_ff @(posedge clk) begin
            if (!rst_n)       q <= 1'b0;
            else if (abort_i) q <= 1'b0;
            else              q <= set_v[ch];
         end
         assign out_v[ch] = q;
      end else begin : g_stretch
         logic [PW_W-1:0] left_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                left_q <= '0;
            else if (abort_i)          left_q <= '0;
            else if (set_v[ch])        left_q <= PW_W'(PULSE_CYC);
            else if (left_q != '0)     left_q <= left_q - 1'b1;
         end
         assign out_v[ch] = (left_q != '0);
      end
   end

   assign scan_a_o = out_v[CH_SCAN_A];
   assign scan_b_o = out_v[CH_SCAN_B];
   assign cam_o    = out_v[CH_CAM];
   assign focus_o  = out_v[CH_FOCUS];
   assign stage_o  = out_v[CH_STAGE];
endmodule

// File: rtl/zs_trig_seq.sv
module zs_trig_seq import zs_pkg::*; #(
   parameter int CNT_W     = 16,
   parameter int STEP_W    = 10,
   parameter int PULSE_CYC = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic              mode_swap_i,
   input  logic [CNT_W-1:0]  phase_dly_i,
   input  logic [CNT_W-1:0]  start_dly_i,
   input  logic [CNT_W-1:0]  focus_dly_i,
   input  logic [CNT_W-1:0]  sweep_dly_i,
   input  logic [STEP_W-1:0] num_steps_i,
   input  logic              stage_sync_i,
   output logic              scan_a_o,
   output logic              scan_b_o,
   output logic              cam_trig_o,
   output logic              focus_trig_o,
   output logic              stage_trig_o,
   output logic              busy_o,
   output logic              done_o
);
   if (CNT_W < 1)     begin : g_bad_cnt   $error("CNT_W must be at least 1");     end
   if (STEP_W < 1)    begin : g_bad_step  $error("STEP_W must be at least 1");    end
   if (PULSE_CYC < 1) begin : g_bad_pulse $error("PULSE_CYC must be at least 1"); end

   typedef struct packed {
      logic             swap;
      logic [CNT_W-1:0] focus_dly;
      logic [CNT_W-1:0] sweep_dly;
   } run_cfg_t;

   seq_state_e        state_q;
   run_cfg_t          cfg_q;
   logic [STEP_W-1:0] steps_left_q;
   logic              done_q;

   logic accept, launch, zero_run, fire_frame, step_end, last_step;
   logic scan_busy, scan_a_set, scan_b_set;
   logic st_run, st_fire, gap_run, gap_fire, sw_run, sw_fire;

   assign accept     = start_i && !busy_o && !stop_i;
   assign launch     = accept && (num_steps_i != '0);
   assign zero_run   = accept && (num_steps_i == '0);
   assign fire_frame = (state_q == ST_WAIT_RDY) && !stage_sync_i && !stop_i;
   assign step_end   = (state_q == ST_FRAME)
                       && (!gap_run || gap_fire) && (!sw_run || sw_fire);
   assign last_step  = (steps_left_q == STEP_W'(1));

   zs_scan_pair #(.CNT_W(CNT_W)) u_scan (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch_i (launch),
      .abort_i  (stop_i),
      .phase_i  (phase_dly_i),
      .a_set_o  (scan_a_set),
      .b_set_o  (scan_b_set),
      .busy_o   (scan_busy)
   );

   zs_delay_cnt #(.CNT_W(CNT_W)) u_startup (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (stop_i),
      .load_i (launch),
      .val_i  (start_dly_i),
      .run_o  (st_run),
      .fire_o (st_fire)
   );

   zs_delay_cnt #(.CNT_W(CNT_W)) u_gap (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (stop_i),
      .load_i (fire_frame),
      .val_i  (cfg_q.focus_dly),
      .run_o  (gap_run),
      .fire_o (gap_fire)
   );

   zs_delay_cnt #(.CNT_W(CNT_W)) u_sweep (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (stop_i),
      .load_i (fire_frame),
      .val_i  (cfg_q.sweep_dly),
      .run_o  (sw_run),
      .fire_o (sw_fire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         cfg_q        <= '0;
         steps_left_q <= '0;
         done_q       <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (stop_i) begin
            state_q <= ST_IDLE;
         end else begin
            unique case (state_q)
               ST_IDLE: begin
                  if (launch) begin
                     state_q         <= ST_STARTUP;
                     steps_left_q    <= num_steps_i;
                     cfg_q.swap      <= mode_swap_i;
                     cfg_q.focus_dly <= focus_dly_i;
                     cfg_q.sweep_dly <= sweep_dly_i;
                  end
                  if (zero_run) done_q <= 1'b1;
               end
               ST_STARTUP: begin
                  if (st_fire) state_q <= ST_WAIT_RDY;
               end
               ST_WAIT_RDY: begin
                  if (!stage_sync_i) state_q <= ST_FRAME;
               end
               ST_FRAME: begin
                  if (step_end) begin
                     if (last_step) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                     end else begin
                        state_q      <= ST_WAIT_RDY;
                        steps_left_q <= steps_left_q - 1'b1;
                     end
                  end
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   zs_trig_route #(.PULSE_CYC(PULSE_CYC)) u_route (
      .clk      (clk),
      .rst_n    (rst_n),
      .abort_i  (stop_i),
      .swap_i   (cfg_q.swap),
      .scan_a_i (scan_a_set),
      .scan_b_i (scan_b_set),
      .first_i  (fire_frame),
      .second_i (gap_fire && !stop_i),
      .stage_i  (sw_fire && !stop_i),
      .scan_a_o (scan_a_o),
      .scan_b_o (scan_b_o),
      .cam_o    (cam_trig_o),
      .focus_o  (focus_trig_o),
      .stage_o  (stage_trig_o)
   );

   assign busy_o = (state_q != ST_IDLE) || scan_busy || st_run || gap_run || sw_run;
   assign done_o = done_q;
endmodule

// File: rtl/zs_trig_seq_chk.sv
module zs_trig_seq_chk import zs_pkg::*; #(
   parameter int STEP_W    = 10,
   parameter int PULSE_CYC = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              stop_i,
   input logic              stage_sync_i,
   input logic [STEP_W-1:0] num_steps_i,
   input seq_state_e        state_q,
   input logic              scan_a_o,
   input logic              scan_b_o,
   input logic              cam_trig_o,
   input logic              focus_trig_o,
   input logic              stage_trig_o,
   input logic              busy_o,
   input logic              done_o
);
   a_r2_launch_scan_a: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !stop_i && !busy_o && num_steps_i != '0) |=> (scan_a_o && busy_o));

   a_r4_frame_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FRAME && $past(state_q) == ST_WAIT_RDY) |-> !$past(stage_sync_i));

   a_r9_stop_quiets: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i |=> (!busy_o && !done_o && !scan_a_o && !scan_b_o
                  && !cam_trig_o && !focus_trig_o && !stage_trig_o));

   a_r11_zero_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !stop_i && !busy_o && num_steps_i == '0) |=> (done_o && !busy_o && !scan_a_o));

   if (PULSE_CYC == 1) begin : g_single
      a_r10_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
         (start_i && busy_o) |=> !scan_a_o);

      a_r13_cam_focus_apart: assert property (@(posedge clk) disable iff (!rst_n)
         !(cam_trig_o && focus_trig_o));

      a_r13_stage_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
         stage_trig_o |=> !stage_trig_o);
   end
endmodule

bind zs_trig_seq zs_trig_seq_chk #(.STEP_W(STEP_W), .PULSE_CYC(PULSE_CYC)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_i      (start_i),
   .stop_i       (stop_i),
   .stage_sync_i (stage_sync_i),
   .num_steps_i  (num_steps_i),
   .state_q      (state_q),
   .scan_a_o     (scan_a_o),
   .scan_b_o     (scan_b_o),
   .cam_trig_o   (cam_trig_o),
   .focus_trig_o (focus_trig_o),
   .stage_trig_o (stage_trig_o),
   .busy_o       (busy_o),
   .done_o       (done_o)
);

// File: tb/zs_trig_seq_tb_top.sv
`timescale 1ns/1ps
module zs_trig_seq_tb_top;
   localparam int CW = 16;
   localparam int SW = 10;
   // expected mask bits: 0 scan_a, 1 scan_b, 2 cam, 3 focus, 4 stage, 5 done
   localparam int B_SA = 0, B_SB = 1, B_CAM = 2, B_FOC = 3, B_STG = 4, B_DONE = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0, stop_i = 1'b0, mode_swap_i = 1'b0, stage_sync_i = 1'b0;
   logic [CW-1:0] phase_dly_i = '0, start_dly_i = '0, focus_dly_i = '0, sweep_dly_i = '0;
   logic [SW-1:0] num_steps_i = '0;
   logic scan_a_o, scan_b_o, cam_trig_o, focus_trig_o, stage_trig_o, busy_o, done_o;

   always #2 clk = ~clk;

   zs_trig_seq #(.CNT_W(CW), .STEP_W(SW), .PULSE_CYC(1)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
      .mode_swap_i(mode_swap_i), .phase_dly_i(phase_dly_i), .start_dly_i(start_dly_i),
      .focus_dly_i(focus_dly_i), .sweep_dly_i(sweep_dly_i), .num_steps_i(num_steps_i),
      .stage_sync_i(stage_sync_i), .scan_a_o(scan_a_o), .scan_b_o(scan_b_o),
      .cam_trig_o(cam_trig_o), .focus_trig_o(focus_trig_o), .stage_trig_o(stage_trig_o),
      .busy_o(busy_o), .done_o(done_o));

   typedef struct { int cyc; logic [5:0] m; } exp_t;
   exp_t  exp_q[$];
   int    cyc = 0;
   int    checks = 0;
   int    errors = 0;
   string cur_req = "R1";
   logic  mon_on = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic void push(int c, int b);
      exp_t e;
      e.cyc = c;
      e.m   = 6'(1) << b;
      exp_q.push_back(e);
   endfunction

   // scoreboard monitor: compares all pulse outputs every cycle
   always @(negedge clk) begin
      if (mon_on) begin
         logic [5:0] expm, act;
         expm = '0;
         for (int i = exp_q.size() - 1; i >= 0; i--) begin
            if (exp_q[i].cyc == cyc) expm |= exp_q[i].m;
            if (exp_q[i].cyc <= cyc) exp_q.delete(i);
         end
         act = {done_o, stage_trig_o, focus_trig_o, cam_trig_o, scan_b_o, scan_a_o};
         if (expm != '0 || act != '0) begin
            checks++;
            if (act !== expm) begin
               errors++;
               $display("FAIL %s cycle %0d: outputs actual=%b expected=%b", cur_req, cyc, act, expm);
            end
         end
      end
   end

   task automatic chk(input logic cond, input string req, input int act, input int expv);
      checks++;
      if (!cond) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // frame schedule with stage ready from frame f1 on; returns done cycle
   function automatic int gen_frames(int f1, int g, int w, int n, bit swap);
      int f = f1, te = 0, mx;
      mx = (g > w) ? g : w;
      for (int i = 0; i < n; i++) begin
         push(f, swap ? B_FOC : B_CAM);
         push(f + g + 1, swap ? B_CAM : B_FOC);
         push(f + w + 1, B_STG);
         te = f + mx + 1;
         if (i == n - 1) push(te, B_DONE);
         f = te + 1;
      end
      return te;
   endfunction

   // programs the ports, pulses start and returns the k=0 cycle
   task automatic kick(input int p, input int s, input int g, input int w,
                       input int n, input bit swap, output int b);
      @(negedge clk);
      phase_dly_i = CW'(p); start_dly_i = CW'(s); focus_dly_i = CW'(g);
      sweep_dly_i = CW'(w); num_steps_i = SW'(n); mode_swap_i = swap;
      b = cyc + 1;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic wait_until(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   task automatic full_run(input int p, input int s, input int g, input int w,
                           input int n, input bit swap, input string req);
      int b, te;
      cur_req = req;
      b = cyc + 2;
      push(b, B_SA);
      push(b + p + 1, B_SB);
      te = gen_frames(b + s + 2, g, w, n, swap);
      kick(p, s, g, w, n, swap, b);
      wait_until(te + 2);
      chk(busy_o == 1'b0, {req, " R8 busy low after done"}, busy_o, 0);
   endtask

   initial begin
      int b, te;
      repeat (5) @(negedge clk);
      // R1: reset state
      chk({scan_a_o, scan_b_o, cam_trig_o, focus_trig_o, stage_trig_o, busy_o, done_o} == '0,
          "R1 reset outputs", int'({scan_a_o, scan_b_o, cam_trig_o, focus_trig_o,
                                    stage_trig_o, busy_o, done_o}), 0);
      rst_n = 1'b1;
      mon_on = 1'b1;
      @(negedge clk);
      chk(busy_o == 1'b0, "R1 idle after reset", busy_o, 0);

      // R2 R3 R5 R7 R8 R13: default order, three steps, sweep longer than offset
      full_run(3, 4, 2, 5, 3, 1'b0, "R5");
      // R6 R3: swapped order, zero startup and phase, offset longer than sweep
      full_run(0, 0, 6, 1, 2, 1'b1, "R6");
      // R3 R7: all delays zero
      full_run(0, 0, 0, 0, 1, 1'b0, "R3");

      // R4: stage busy holds off the frame
      cur_req = "R4";
      stage_sync_i = 1'b1;
      b = cyc + 2;
      push(b, B_SA);
      push(b + 2, B_SB);
      kick(1, 2, 1, 3, 1, 1'b0, b);
      wait_until(b + 8);
      chk(busy_o == 1'b1, "R4 busy while stage not ready", busy_o, 1);
      te = gen_frames(b + 9, 1, 3, 1, 1'b0);
      stage_sync_i = 1'b0;
      wait_until(te + 2);
      chk(busy_o == 1'b0, "R4 busy low after run", busy_o, 0);

      // R10 R12: restart and changed settings during a run
      cur_req = "R10";
      b = cyc + 2;
      push(b, B_SA);
      push(b + 3, B_SB);
      te = gen_frames(b + 3 + 2, 4, 2, 2, 1'b0);
      kick(2, 3, 4, 2, 2, 1'b0, b);
      phase_dly_i = 9; start_dly_i = 1; focus_dly_i = 0; sweep_dly_i = 7;
      num_steps_i = 5; mode_swap_i = 1'b1;
      cur_req = "R12";
      wait_until(b + 7);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      cur_req = "R10";
      wait_until(te + 2);
      chk(busy_o == 1'b0, "R10 run length unchanged by restart", busy_o, 0);

      // R9: stop while waiting for the stage
      cur_req = "R9";
      stage_sync_i = 1'b1;
      b = cyc + 2;
      push(b, B_SA);
      push(b + 1, B_SB);
      kick(0, 1, 1, 1, 2, 1'b0, b);
      wait_until(b + 6);
      stop_i = 1'b1;
      @(negedge clk);
      stop_i = 1'b0;
      chk(busy_o == 1'b0, "R9 busy cleared by stop", busy_o, 0);
      stage_sync_i = 1'b0;
      repeat (20) @(negedge clk);
      chk(busy_o == 1'b0, "R9 stays idle after stop", busy_o, 0);

      // R11: zero steps
      cur_req = "R11";
      b = cyc + 2;
      push(b, B_DONE);
      kick(2, 2, 2, 2, 0, 1'b0, b);
      chk(busy_o == 1'b0, "R11 no busy on zero steps", busy_o, 0);
      repeat (10) @(negedge clk);

      // R8: run after the above still behaves
      full_run(1, 0, 3, 3, 4, 1'b1, "R8");
      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R8 all expected pulses seen", exp_q.size(), 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule